// File: doc/BRIEF.md
# DMA Channel Error and Interrupt Control

This block sits beside one channel of a descriptor-driven DMA engine. Software reaches its four-bit command register through a register write port that carries byte enables. The data mover reports two kinds of event: a descriptor finishing, which may ask for an interrupt, and an error. Each error is tagged as affiliated (caused by the current transfer) or unaffiliated. From these events and the stored settings, the block decides whether the channel aborts, whether a completion write is requested, and whether an interrupt is raised.

Interrupts pass through a one-shot latch. Raising an interrupt sets the latch. While the latch is set, later completions and errors raise nothing. Software re-arms the latch by writing a one to its bit, which allows exactly one further interrupt. The interrupt leaves the block either as a single-cycle message pulse or as a legacy level, and the legacy level can be masked from outside. The two error-policy bits can be changed only when the configuration reports exactly one channel.

Top module: `dma_chan_ctl`

## Requirements
- R1: After reset, every command register bit reads 0, and abort, completion-write, message-interrupt and legacy-interrupt outputs are low.
- R2: A descriptor completion with its interrupt flag set, arriving while the interrupt-disable latch (command bit 0) is 0, raises exactly one interrupt. It sets the latch on the same clock edge. A completion without the flag raises nothing.
- R3: While command bit 0 reads 1, no completion or error raises an interrupt.
- R4: A write to the command address with byte enable 0 set and data bit 0 at 1 clears command bit 0. Data bit 0 at 0, a cleared byte enable, or any other address leaves it unchanged. If a clear and a hardware set land on the same edge, the bit ends at 1 and the interrupt is still raised.
- R5: With command bit 3 (any-error abort) at 0, only an error whose affiliated input is 1 sets the abort output. With bit 3 at 1, every error sets it.
- R6: An error that aborts the channel raises the completion-write output for one cycle exactly when command bit 2 (error completion) is 1. An error that does not abort raises no completion write.
- R7: An error that aborts the channel raises an interrupt when the error-interrupt enable input is 1, subject to the same latch as R2 and R3.
- R8: Command bits 2 and 3 take the written data bits 2 and 3 only when the channel-count input equals 1. Otherwise they keep their stored value. Command bit 1 always reads 0.
- R9: With the mode input at 1, an interrupt appears as a one-cycle message pulse. With the mode input at 0, it appears as a legacy level that stays high until command bit 0 is cleared. The level is forced low while the legacy-disable input is 1.
- R10: Once the abort output is high, it stays high until the channel-reset input is pulsed, which drives it low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanRst | input | 1 | Channel reset pulse that clears the abort output |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register write address |
| regWrData | input | DATA_W | Register write data |
| regByteEn | input | DATA_W/8 | Byte enables of the write |
| chanCount | input | CNT_W | Configured number of channels |
| descDone | input | 1 | Descriptor completion pulse |
| descIntReq | input | 1 | The completing descriptor asks for an interrupt |
| errEvt | input | 1 | Error pulse from the data mover |
| errAffil | input | 1 | 1 = affiliated error, 0 = unaffiliated |
| errIntEn | input | 1 | Error-interrupt enable |
| msiMode | input | 1 | 1 = message interrupt, 0 = legacy level |
| legacyIntDis | input | 1 | Masks the legacy interrupt level |
| cmdRdData | output | DATA_W | Command register read-back |
| abortReq | output | 1 | Sticky abort request |
| cmpWrReq | output | 1 | One-cycle completion-write request |
| msiPulse | output | 1 | One-cycle message interrupt |
| legacyIrq | output | 1 | Legacy interrupt level |

## Verification
The hardest case to reach from the ports is a software clear of the latch and a hardware set of the latch landing on the same clock edge. The bench reaches it by holding a write-one-to-clear and a flagged descriptor completion in the same cycle, right after re-arming the latch, and then checks both the pulse and the bit read back. The error policy is swept over all sixteen combinations of class, any-error abort, error completion and error-interrupt enable. Each combination starts from a fresh reset, so abort stickiness and the channel-reset release are checked for every combination.

// File: rtl/dmactl_pkg.sv
package dmactl_pkg;

  localparam int INTDIS_BIT  = 0;
  localparam int ERRCMP_BIT  = 2;
  localparam int ANYABRT_BIT = 3;

  typedef struct packed {
    logic       clrIntDis;
    logic       ldCfg;
    logic [1:0] cfgVal;     // {anyErrAbrt, errCmpEn}
    logic       setIntDis;
    logic       fireInt;
    logic       setAbort;
    logic       reqCmpWr;
  } ctlStrobes_t;

endpackage

// File: rtl/dmactl_ctrl.sv
module dmactl_ctrl
  import dmactl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h80
) (
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [DATA_W/8-1:0] regByteEn,
  input  logic [CNT_W-1:0]    chanCount,
  input  logic                descDone,
  input  logic                descIntReq,
  input  logic                errEvt,
  input  logic                errAffil,
  input  logic                errIntEn,
  input  logic                intDis,
  input  logic                errCmpEn,
  input  logic                anyErrAbrt,
  output ctlStrobes_t         strb
);

  localparam int BE_W = DATA_W / 8;

  logic cmdHit;
  logic abortHit;
  logic wantInt;
  logic unusedWrBits;

  assign cmdHit   = regWrEn && (regAddr == CMD_ADDR) && regByteEn[0];
  assign abortHit = errEvt && (errAffil || anyErrAbrt);
  assign wantInt  = (descDone && descIntReq) || (abortHit && errIntEn);

  always_comb begin
    strb           = '0;
    strb.clrIntDis = cmdHit && regWrData[INTDIS_BIT];
    strb.ldCfg     = cmdHit && (chanCount == CNT_W'(1));
    strb.cfgVal    = {regWrData[ANYABRT_BIT], regWrData[ERRCMP_BIT]};
    strb.fireInt   = wantInt && !intDis;
    strb.setIntDis = wantInt && !intDis;
    strb.setAbort  = abortHit;
    strb.reqCmpWr  = abortHit && errCmpEn;
  end

  assign unusedWrBits = ^{regWrData[DATA_W-1:ANYABRT_BIT+1], regWrData[1], regByteEn[BE_W-1:1]};

endmodule

// File: rtl/dmactl_regs.sv
module dmactl_regs
  import dmactl_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chanRst,
  input  ctlStrobes_t       strb,
  input  logic              msiMode,
  input  logic              legacyIntDis,
  output logic              intDis,
  output logic              errCmpEn,
  output logic              anyErrAbrt,
  output logic [DATA_W-1:0] cmdRdData,
  output logic              abortReq,
  output logic              cmpWrReq,
  output logic              msiPulse,
  output logic              legacyIrq
);

  logic legPend;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intDis     <= 1'b0;
      errCmpEn   <= 1'b0;
      anyErrAbrt <= 1'b0;
      abortReq   <= 1'b0;
      cmpWrReq   <= 1'b0;
      msiPulse   <= 1'b0;
      legPend    <= 1'b0;
    end else begin
      // hardware set outranks the software clear
      if (strb.setIntDis)      intDis <= 1'b1;
      else if (strb.clrIntDis) intDis <= 1'b0;

      if (strb.ldCfg) {anyErrAbrt, errCmpEn} <= strb.cfgVal;

      if (chanRst)            abortReq <= 1'b0;
      else if (strb.setAbort) abortReq <= 1'b1;

      cmpWrReq <= strb.reqCmpWr;
      msiPulse <= strb.fireInt && msiMode;

      if (strb.fireInt && !msiMode) legPend <= 1'b1;
      else if (strb.clrIntDis)      legPend <= 1'b0;
    end
  end

  assign legacyIrq = legPend && !legacyIntDis;

  always_comb begin
    cmdRdData              = '0;
    cmdRdData[INTDIS_BIT]  = intDis;
    cmdRdData[ERRCMP_BIT]  = errCmpEn;
    cmdRdData[ANYABRT_BIT] = anyErrAbrt;
  end

  assert_msi_needs_armed_R3: assert property (@(posedge clk) disable iff (!rstN)
    msiPulse |-> !$past(intDis));

  assert_latch_set_with_int_R2: assert property (@(posedge clk) disable iff (!rstN)
    msiPulse |-> intDis);

  assert_msi_single_cycle_R9: assert property (@(posedge clk) disable iff (!rstN)
    msiPulse |=> !msiPulse);

  assert_abort_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (abortReq && !chanRst) |=> abortReq);

  assert_cmpwr_enabled_R6: assert property (@(posedge clk) disable iff (!rstN)
    cmpWrReq |-> $past(errCmpEn));

endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
  import dmactl_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int CNT_W    = 4,
  parameter logic [ADDR_W-1:0] CMD_ADDR = 8'h80
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                chanRst,
  input  logic                regWrEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic [DATA_W/8-1:0] regByteEn,
  input  logic [CNT_W-1:0]    chanCount,
  input  logic                descDone,
  input  logic                descIntReq,
  input  logic                errEvt,
  input  logic                errAffil,
  input  logic                errIntEn,
  input  logic                msiMode,
  input  logic                legacyIntDis,
  output logic [DATA_W-1:0]   cmdRdData,
  output logic                abortReq,
  output logic                cmpWrReq,
  output logic                msiPulse,
  output logic                legacyIrq
);

  ctlStrobes_t strb;
  logic intDis;
  logic errCmpEn;
  logic anyErrAbrt;

  dmactl_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CMD_ADDR(CMD_ADDR)
  ) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regByteEn(regByteEn), .chanCount(chanCount), .descDone(descDone),
    .descIntReq(descIntReq), .errEvt(errEvt), .errAffil(errAffil),
    .errIntEn(errIntEn), .intDis(intDis), .errCmpEn(errCmpEn),
    .anyErrAbrt(anyErrAbrt), .strb(strb)
  );

  dmactl_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rstN(rstN), .chanRst(chanRst), .strb(strb),
    .msiMode(msiMode), .legacyIntDis(legacyIntDis), .intDis(intDis),
    .errCmpEn(errCmpEn), .anyErrAbrt(anyErrAbrt), .cmdRdData(cmdRdData),
    .abortReq(abortReq), .cmpWrReq(cmpWrReq), .msiPulse(msiPulse),
    .legacyIrq(legacyIrq)
  );

  assert_cfg_locked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (chanCount != CNT_W'(1)) |=> $stable(cmdRdData[ANYABRT_BIT:ERRCMP_BIT]));

endmodule

// File: tb/dma_chan_ctl_tb.sv
module dma_chan_ctl_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] CMD = 8'h80;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chanRst = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = CMD;
  logic [15:0] regWrData = '0;
  logic [1:0]  regByteEn = '0;
  logic [3:0]  chanCount = 4'd1;
  logic        descDone = 1'b0;
  logic        descIntReq = 1'b0;
  logic        errEvt = 1'b0;
  logic        errAffil = 1'b0;
  logic        errIntEn = 1'b0;
  logic        msiMode = 1'b1;
  logic        legacyIntDis = 1'b0;
  logic [15:0] cmdRdData;
  logic        abortReq, cmpWrReq, msiPulse, legacyIrq;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctl u_dut (
    .clk(clk), .rstN(rstN), .chanRst(chanRst), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regByteEn(regByteEn),
    .chanCount(chanCount), .descDone(descDone), .descIntReq(descIntReq),
    .errEvt(errEvt), .errAffil(errAffil), .errIntEn(errIntEn),
    .msiMode(msiMode), .legacyIntDis(legacyIntDis), .cmdRdData(cmdRdData),
    .abortReq(abortReq), .cmpWrReq(cmpWrReq), .msiPulse(msiPulse),
    .legacyIrq(legacyIrq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic wrCmd(input logic [15:0] d, input logic [1:0] be = 2'b01,
                       input logic [7:0] a = CMD);
    regWrEn = 1'b1; regWrData = d; regByteEn = be; regAddr = a;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0; regAddr = CMD;
  endtask

  task automatic desc(input logic req);
    descDone = 1'b1; descIntReq = req;
    @(negedge clk);
    descDone = 1'b0; descIntReq = 1'b0;
  endtask

  task automatic err(input logic affil);
    errEvt = 1'b1; errAffil = affil;
    @(negedge clk);
    errEvt = 1'b0; errAffil = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();
    // R1 reset state
    check("R1 cmd", cmdRdData, 16'h0);
    check("R1 outs", {12'h0, abortReq, cmpWrReq, msiPulse, legacyIrq}, 16'h0);

    // R2 completion without flag raises nothing
    desc(1'b0);
    check("R2 noflag msi", msiPulse, 0);
    check("R2 noflag latch", cmdRdData, 16'h0);
    // R2 flagged completion
    desc(1'b1);
    check("R2 msi", msiPulse, 1);
    check("R2 latch set", cmdRdData, 16'h1);
    @(negedge clk);
    check("R9 msi one cycle", msiPulse, 0);

    // R3 latched: further events silent
    desc(1'b1);
    check("R3 desc silent", msiPulse, 0);

    // R4 ignored writes
    wrCmd(16'h0000);
    check("R4 write0 keeps", cmdRdData[0], 1);
    wrCmd(16'h0001, 2'b10);
    check("R4 no byte enable keeps", cmdRdData[0], 1);
    wrCmd(16'h0001, 2'b01, 8'h84);
    check("R4 other address keeps", cmdRdData[0], 1);
    wrCmd(16'h0001);
    check("R4 w1c clears", cmdRdData[0], 0);
    desc(1'b1);
    check("R4 rearmed one interrupt", msiPulse, 1);
    // R4 collision: clear and hardware set on the same edge
    wrCmd(16'h0001);
    regWrEn = 1'b1; regWrData = 16'h0001; regByteEn = 2'b01;
    descDone = 1'b1; descIntReq = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regByteEn = '0; descDone = 1'b0; descIntReq = 1'b0;
    check("R4 collision msi", msiPulse, 1);
    check("R4 collision set wins", cmdRdData[0], 1);

    // R8 config writability by channel count
    doReset();
    for (int n = 0; n < 4; n++) begin
      chanCount = 4'(n);
      wrCmd(16'h000E);
      check("R8 bit1 zero / cfg lock", cmdRdData, (n == 1) ? 16'h000C : 16'h0000);
      if (n == 1) begin
        chanCount = 4'd2;
        wrCmd(16'h0000);
        check("R8 locked keeps value", cmdRdData, 16'h000C);
        chanCount = 4'd1;
        wrCmd(16'h0000);
        check("R8 unlocked clears", cmdRdData, 16'h0000);
      end
    end
    chanCount = 4'd1;

    // R5 R6 R7 R10 sweep of error policy
    for (int c = 0; c < 16; c++) begin
      logic affil, anyA, cmpE, intE, expAb;
      affil = c[0]; anyA = c[1]; cmpE = c[2]; intE = c[3];
      expAb = affil | anyA;
      doReset();
      wrCmd({12'h0, anyA, cmpE, 2'b00});
      errIntEn = intE;
      err(affil);
      check("R5 abort", abortReq, expAb);
      check("R6 cmpwr", cmpWrReq, expAb & cmpE);
      check("R7 error interrupt", msiPulse, expAb & intE);
      repeat (2) @(negedge clk);
      check("R10 abort held", abortReq, expAb);
      check("R6 cmpwr one cycle", cmpWrReq, 0);
      chanRst = 1'b1;
      @(negedge clk);
      chanRst = 1'b0;
      check("R10 chanRst clears", abortReq, 0);
      errIntEn = 1'b0;
    end

    // R7 error interrupt obeys latch
    doReset();
    errIntEn = 1'b1;
    desc(1'b1);
    err(1'b1);
    check("R7 latched error silent", msiPulse, 0);
    check("R7 abort still set", abortReq, 1);
    errIntEn = 1'b0;

    // R9 legacy mode
    doReset();
    msiMode = 1'b0;
    desc(1'b1);
    check("R9 legacy no msi", msiPulse, 0);
    check("R9 legacy level", legacyIrq, 1);
    repeat (3) @(negedge clk);
    check("R9 legacy held", legacyIrq, 1);
    legacyIntDis = 1'b1;
    #1;
    check("R9 legacy masked", legacyIrq, 0);
    legacyIntDis = 1'b0;
    #1;
    check("R9 legacy unmasked", legacyIrq, 1);
    wrCmd(16'h0001);
    check("R9 legacy cleared by rearm", legacyIrq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule